// File: doc/BRIEF.md
# NaN Classifier and Quieting Unit

This combinational unit looks at a single floating-point operand in either binary32 or binary64 format. It reports whether the operand is a quiet NaN or a signaling NaN. It also returns a quieted copy of the operand and the default NaN for the selected format. A floating-point datapath uses it ahead of NaN propagation, where a signaling operand has to be silenced before it is forwarded and the invalid condition has to be flagged.

Two static parameters set the conventions. `INV_POL` picks the meaning of the top fraction bit:
- At 0, a set top fraction bit marks a quiet NaN.
- At 1, a set top fraction bit marks a signaling NaN, and quieting substitutes the default NaN.

`DNAN_SEL` picks one of four default-NaN layouts. Each layout is generated for both formats from their exponent and fraction widths.

Top module: `nan_quieter`

## Requirements
- R1: With `INV_POL`=0 and `fmt_i`=0 (binary32), the operand is `data_i[31:0]`. `is_qnan_o` is 1 exactly when bits 30..23 are all ones and bit 22 is set.
- R2: With `INV_POL`=0 and binary32, `is_snan_o` is 1 exactly when bits 30..23 are all ones, bit 22 is clear and bits 21..0 are not all zero.
- R3: For an input that is not a signaling NaN, `quiet_o` equals the operand, zero-extended. For infinity and for any non-NaN value, both classification outputs are 0.
- R4: With `fmt_i`=1 (binary64), the operand is all of `data_i`. The exponent is bits 62..52 and the top fraction bit is bit 51; otherwise classification follows R1/R2.
- R5: With `INV_POL`=1, the two tests swap roles. A NaN with the top fraction bit set is signaling. A NaN with that bit clear and a non-zero remaining fraction is quiet.
- R6: With `INV_POL`=0, quieting a signaling NaN sets bit 22 (binary32) or bit 51 (binary64) and leaves sign, exponent and all other fraction bits unchanged.
- R7: With `INV_POL`=1, quieting a signaling NaN returns the format's default NaN.
- R8: `dnan_o` is the default NaN of the selected format, chosen by `DNAN_SEL`:
  - 0 gives 0x7FFFFFFF / 0x7FFFFFFFFFFFFFFF
  - 1 gives 0x7FC00000 / 0x7FF8000000000000
  - 2 gives 0x7FBFFFFF / 0x7FF7FFFFFFFFFFFF
  - 3 gives 0xFFC00000 / 0xFFF8000000000000
- R9: In binary32 mode, `data_i[63:32]` has no effect on any output, and `quiet_o[63:32]` and `dnan_o[63:32]` are zero.
- R10: `is_qnan_o` and `is_snan_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fmt_i | input | 1 | Format select: 0 binary32 (low half), 1 binary64 |
| data_i | input | 64 | Operand |
| is_qnan_o | output | 1 | Operand is a quiet NaN |
| is_snan_o | output | 1 | Operand is a signaling NaN |
| quiet_o | output | 64 | Operand with a signaling NaN quieted, zero-extended in binary32 mode |
| dnan_o | output | 64 | Default NaN of the selected format, zero-extended in binary32 mode |

## Verification
The hardest inputs to reach are the boundary encodings. These are an all-ones exponent with only the lowest fraction bit set, and an all-ones exponent with a zero fraction (infinity). They separate a signaling NaN from infinity, and uniform random words almost never produce them. The stimulus therefore forces the exponent field to all ones in most random vectors, and it draws the fraction from empty, single-bit, top-bit-only and random patterns. The same vectors go to a normal-polarity and an inverted-polarity instance, which exercises the swapped tests. In binary32 mode, random junk in the upper half of the data port exercises R9.

// File: rtl/nanq_pkg.sv
package nanq_pkg;
  localparam int DATA_W   = 64;
  localparam int NUM_FMT  = 2;
  localparam int S_EXP_W  = 8;
  localparam int S_FRAC_W = 23;
  localparam int D_EXP_W  = 11;
  localparam int D_FRAC_W = 52;

  typedef enum logic {
    FMT_S = 1'b0,
    FMT_D = 1'b1
  } fmt_e;

  typedef enum logic [1:0] {
    DN_ONES = 2'd0,
    DN_QPOS = 2'd1,
    DN_SINV = 2'd2,
    DN_QNEG = 2'd3
  } dnan_e;

  function automatic int exp_w(int f);
    return (f == 0) ? S_EXP_W : D_EXP_W;
  endfunction

  function automatic int frac_w(int f);
    return (f == 0) ? S_FRAC_W : D_FRAC_W;
  endfunction
endpackage

// File: rtl/nanq_classify.sv
module nanq_classify #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit INV_POL = 1'b0,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val_i,
  output logic         is_qnan_o,
  output logic         is_snan_o
);
  logic exp_ones, top_bit, low_nz, nan_top, nan_low;

  always_comb begin
    exp_ones = &val_i[W-2:FRAC_W];
    top_bit  = val_i[FRAC_W-1];
    low_nz   = |val_i[FRAC_W-2:0];
    nan_top  = exp_ones & top_bit;
    nan_low  = exp_ones & ~top_bit & low_nz;
  end

  generate
    if (INV_POL) begin : g_inv
      assign is_snan_o = nan_top;
      assign is_qnan_o = nan_low;
    end else begin : g_norm
      assign is_qnan_o = nan_top;
      assign is_snan_o = nan_low;
    end
  endgenerate

  always_comb begin
    // R10
    excl_chk: assert (!(is_qnan_o && is_snan_o))
      else $error("quiet and signaling both set");
    // R3
    if (!exp_ones)
      non_nan_chk: assert (!is_qnan_o && !is_snan_o)
        else $error("finite value classified as NaN");
  end
endmodule

// File: rtl/nanq_default_gen.sv
module nanq_default_gen #(
  parameter int             EXP_W    = 8,
  parameter int             FRAC_W   = 23,
  parameter nanq_pkg::dnan_e DNAN_SEL = nanq_pkg::DN_QNEG,
  localparam int            W        = 1 + EXP_W + FRAC_W
) (
  output logic [W-1:0] dnan_o
);
  import nanq_pkg::*;

  always_comb begin
    unique case (DNAN_SEL)
      DN_ONES: dnan_o = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
      DN_QPOS: dnan_o = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
      DN_SINV: dnan_o = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
      default: dnan_o = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    endcase
  end
endmodule

// File: rtl/nanq_silence.sv
module nanq_silence #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit INV_POL = 1'b0,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val_i,
  input  logic         is_snan_i,
  input  logic [W-1:0] dnan_i,
  output logic [W-1:0] quiet_o
);
  localparam logic [W-1:0] QBIT = W'(1) << (FRAC_W - 1);

  generate
    if (INV_POL) begin : g_inv
      assign quiet_o = is_snan_i ? dnan_i : val_i;
    end else begin : g_norm
      assign quiet_o = is_snan_i ? (val_i | QBIT) : val_i;
    end
  endgenerate

  always_comb begin
    if (is_snan_i) begin
      // R6
      still_nan_chk: assert (&quiet_o[W-2:FRAC_W])
        else $error("quieted value lost NaN exponent");
      // R6
      if (!INV_POL)
        sign_keep_chk: assert (quiet_o[W-1] == val_i[W-1] && quiet_o[FRAC_W-1])
          else $error("quieting changed sign or left quiet bit clear");
    end
  end
endmodule

// File: rtl/nanq_lane.sv
module nanq_lane #(
  parameter int             EXP_W    = 8,
  parameter int             FRAC_W   = 23,
  parameter bit             INV_POL  = 1'b0,
  parameter nanq_pkg::dnan_e DNAN_SEL = nanq_pkg::DN_QNEG,
  localparam int            W        = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val_i,
  output logic         is_qnan_o,
  output logic         is_snan_o,
  output logic [W-1:0] quiet_o,
  output logic [W-1:0] dnan_o
);
  nanq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INV_POL(INV_POL)) u_cls (
    .val_i     (val_i),
    .is_qnan_o (is_qnan_o),
    .is_snan_o (is_snan_o)
  );

  nanq_default_gen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .DNAN_SEL(DNAN_SEL)) u_dn (
    .dnan_o (dnan_o)
  );

  nanq_silence #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INV_POL(INV_POL)) u_sil (
    .val_i     (val_i),
    .is_snan_i (is_snan_o),
    .dnan_i    (dnan_o),
    .quiet_o   (quiet_o)
  );
endmodule

// File: rtl/nan_quieter.sv
module nan_quieter #(
  parameter bit              INV_POL  = 1'b0,
  parameter nanq_pkg::dnan_e DNAN_SEL = nanq_pkg::DN_QNEG
) (
  input  logic        fmt_i,
  input  logic [63:0] data_i,
  output logic        is_qnan_o,
  output logic        is_snan_o,
  output logic [63:0] quiet_o,
  output logic [63:0] dnan_o
);
  import nanq_pkg::*;

  logic              lane_q [NUM_FMT];
  logic              lane_s [NUM_FMT];
  logic [DATA_W-1:0] lane_quiet [NUM_FMT];
  logic [DATA_W-1:0] lane_dn [NUM_FMT];
  logic [DATA_W-1:0] lane_in [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    localparam int EW = exp_w(g);
    localparam int FW = frac_w(g);
    localparam int LW = 1 + EW + FW;
    logic [LW-1:0] q_w, d_w;

    assign lane_in[g] = DATA_W'(data_i[LW-1:0]);

    nanq_lane #(
      .EXP_W(EW), .FRAC_W(FW), .INV_POL(INV_POL), .DNAN_SEL(DNAN_SEL)
    ) u_lane (
      .val_i     (data_i[LW-1:0]),
      .is_qnan_o (lane_q[g]),
      .is_snan_o (lane_s[g]),
      .quiet_o   (q_w),
      .dnan_o    (d_w)
    );

    assign lane_quiet[g] = DATA_W'(q_w);
    assign lane_dn[g]    = DATA_W'(d_w);
  end

  always_comb begin
    is_qnan_o = lane_q[fmt_i];
    is_snan_o = lane_s[fmt_i];
    quiet_o   = lane_quiet[fmt_i];
    dnan_o    = lane_dn[fmt_i];
  end

  always_comb begin
    // R3
    if (!is_snan_o)
      pass_chk: assert (quiet_o == lane_in[fmt_i])
        else $error("non-signaling operand altered");
    // R9
    if (fmt_i == FMT_S)
      upper_zero_chk: assert (quiet_o[63:32] == '0 && dnan_o[63:32] == '0)
        else $error("upper half non-zero in binary32 mode");
    // R8
    dnan_exp_chk: assert (fmt_i ? (&dnan_o[62:52]) : (&dnan_o[30:23]))
      else $error("default NaN exponent not all ones");
  end
endmodule

// File: tb/nan_quieter_test.sv
module nan_quieter_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fmt;
  logic [63:0] data;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  logic        n_q, n_s, i_q, i_s;
  logic [63:0] n_quiet, n_dn, i_quiet, i_dn;
  logic        x_q [4];
  logic        x_s [4];
  logic [63:0] x_quiet [4];
  logic [63:0] x_dn [4];

  nan_quieter #(.INV_POL(1'b0), .DNAN_SEL(nanq_pkg::DN_QNEG)) uut (
    .fmt_i(fmt), .data_i(data), .is_qnan_o(n_q), .is_snan_o(n_s),
    .quiet_o(n_quiet), .dnan_o(n_dn));

  nan_quieter #(.INV_POL(1'b1), .DNAN_SEL(nanq_pkg::DN_SINV)) uut_inv (
    .fmt_i(fmt), .data_i(data), .is_qnan_o(i_q), .is_snan_o(i_s),
    .quiet_o(i_quiet), .dnan_o(i_dn));

  for (genvar k = 0; k < 4; k++) begin : g_sel
    nan_quieter #(.INV_POL(1'b0), .DNAN_SEL(nanq_pkg::dnan_e'(k))) u_sel (
      .fmt_i(fmt), .data_i(data), .is_qnan_o(x_q[k]), .is_snan_o(x_s[k]),
      .quiet_o(x_quiet[k]), .dnan_o(x_dn[k]));
  end

  function automatic logic [63:0] ref_dn(bit f, int sel);
    logic [31:0] t32 [4] = '{32'h7FFFFFFF, 32'h7FC00000, 32'h7FBFFFFF, 32'hFFC00000};
    logic [63:0] t64 [4] = '{64'h7FFFFFFFFFFFFFFF, 64'h7FF8000000000000,
                             64'h7FF7FFFFFFFFFFFF, 64'hFFF8000000000000};
    return f ? t64[sel] : {32'h0, t32[sel]};
  endfunction

  task automatic ref_model(input bit f, input logic [63:0] d, input bit inv, input int sel,
                           output bit q, output bit s, output logic [63:0] qo);
    bit top_set, low_set;
    logic [63:0] x;
    if (!f) begin
      logic [31:0] w, sh;
      w = d[31:0];
      sh = w << 1;
      x = {32'h0, w};
      top_set = (sh >= 32'hFF800000);
      low_set = (((w >> 22) & 32'h1FF) == 32'h1FE) && ((w & 32'h003FFFFF) != 0);
    end else begin
      logic [63:0] sh;
      sh = d << 1;
      x = d;
      top_set = (sh >= 64'hFFF0000000000000);
      low_set = (((d >> 51) & 64'hFFF) == 64'hFFE) && ((d & 64'h0007FFFFFFFFFFFF) != 0);
    end
    q = inv ? low_set : top_set;
    s = inv ? top_set : low_set;
    if (!s) qo = x;
    else if (inv) qo = ref_dn(f, sel);
    else qo = f ? (x | 64'h0008000000000000) : (x | 64'h0000000000400000);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (fmt=%0d data=%h)", req, act, exp, fmt, data);
    end
  endtask

  task automatic apply(input bit f, input logic [63:0] d);
    bit q, s;
    logic [63:0] qo;
    @(posedge clk);
    #1;
    fmt = f;
    data = d;
    @(negedge clk);
    ref_model(f, d, 1'b0, 3, q, s, qo);
    chk(f ? "R4 qnan" : "R1 qnan", 64'(n_q), 64'(q));
    chk(f ? "R4 snan" : "R2 snan", 64'(n_s), 64'(s));
    chk(s ? "R6 quiet" : "R3 pass", n_quiet, qo);
    chk("R10 excl", 64'(n_q & n_s), 64'h0);
    ref_model(f, d, 1'b1, 2, q, s, qo);
    chk("R5 qnan inv", 64'(i_q), 64'(q));
    chk("R5 snan inv", 64'(i_s), 64'(s));
    chk(s ? "R7 quiet inv" : "R3 pass inv", i_quiet, qo);
    for (int k = 0; k < 4; k++) chk("R8 dnan", x_dn[k], ref_dn(f, k));
    if (!f) chk("R9 upper", {n_quiet[63:32], i_quiet[63:32]}, 64'h0);
  endtask

  function automatic logic [63:0] gen_frac(int w);
    logic [63:0] m = (64'h1 << w) - 1;
    case ($urandom_range(0, 4))
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'h1 << (w - 1);
      3: return 64'h1 << $urandom_range(0, w - 1);
      default: return {$urandom, $urandom} & m;
    endcase
  endfunction

  initial begin
    fmt = 1'b0;
    data = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R3 reset-time state with zero operand
    chk("R3 idle flags", {62'h0, n_q, n_s}, 64'h0);
    chk("R3 idle quiet", n_quiet, 64'h0);
    chk("R8 idle dnan", n_dn, 64'h00000000FFC00000);

    apply(1'b0, 64'h000000007FC00000);   // R1
    apply(1'b0, 64'h000000007F800001);   // R2 lowest payload
    apply(1'b0, 64'h00000000FFA00000);   // R6 sign kept
    apply(1'b0, 64'h000000007F800000);   // R3 infinity
    apply(1'b0, 64'h00000000FF800000);
    apply(1'b0, 64'h000000003F800000);
    apply(1'b0, 64'h000000007FFFFFFF);
    apply(1'b0, 64'hDEADBEEF7F800001);   // R9 upper junk
    apply(1'b0, 64'hFFFFFFFF00000000);   // R9
    apply(1'b1, 64'h7FF8000000000000);   // R4
    apply(1'b1, 64'h7FF0000000000001);   // R4/R6
    apply(1'b1, 64'hFFF0000000000000);   // R3 infinity
    apply(1'b1, 64'h7FF4000000000000);
    apply(1'b1, 64'h000000007FC00000);   // binary32 pattern in binary64 mode
    // R8 explicit
    chk("R8 inv dnan", i_dn, 64'h7FF7FFFFFFFFFFFF);

    for (int n = 0; n < 600; n++) begin
      bit f = $urandom_range(0, 1) != 0;
      logic [63:0] d;
      if (!f) begin
        logic [31:0] w = {$urandom_range(0, 1) != 0, 8'hFF, gen_frac(23)[22:0]};
        if ($urandom_range(0, 4) == 0) w = $urandom;
        d = {$urandom, w};
      end else begin
        d = {$urandom_range(0, 1) != 0, 11'h7FF, gen_frac(52)[51:0]};
        if ($urandom_range(0, 4) == 0) d = {$urandom, $urandom};
      end
      apply(f, d);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule